// File: doc/BRIEF.md
# Output Data Bus Inversion Encoder

This block cuts the number of lines that switch on a 16-bit read-data bus while a burst is streaming out. For every word it is handed, it counts how many bits would differ from the word it drove last. When that count reaches 9 or more, it drives the bitwise complement of the word instead. A polarity flag travels beside the bus, so the receiver can tell which words arrive complemented.

The feature starts switched off. A single command pulse switches it on, and only a hardware reset switches it off again. While it is off, words pass straight through and the polarity flag stays low.

The reference word is the value actually placed on the bus, after any complement. It moves only on cycles that carry a valid word, and it returns to zero at reset and at the start of each burst. A second, combinational path serves incoming program data: a word that the sender flags as complemented is restored before use.

Top module: `bus_inv_codec`

## Requirements
- R1: While rstN is low, and on the first cycle after it is released, busData is 0x0000 and busInv is 0.
- R2: While the feature is off, a word presented with wordValid appears unchanged on busData one clock later, and busInv is 0.
- R3: A one-cycle pulse on enableCmd turns the feature on for every later word. No later input, including another pulse or a burstStart, turns it off.
- R4: While the feature is on, if 0 to 8 bits of the new word differ from the reference word, busData takes the word unchanged and busInv is 0.
- R5: While the feature is on, if 9 or more bits differ from the reference word, busData takes the bitwise complement of the word and busInv is 1.
- R6: The reference word is the value last driven on busData, after any complement, and not the raw rdData.
- R7: burstStart resets the reference word to 0x0000. When burstStart and wordValid arrive in the same cycle, that word is compared against 0x0000.
- R8: On a cycle without wordValid, busData, busInv and the reference word keep their values, whatever rdData does.
- R9: pgmWord equals ~pgmData when pgmInv is 1 and equals pgmData when pgmInv is 0. This path is combinational and works whether the feature is on or off.
- R10: A hardware reset turns the feature off again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| enableCmd | input | 1 | One-cycle pulse that turns inversion on |
| burstStart | input | 1 | Marks the start of a burst; resets the reference word |
| wordValid | input | 1 | rdData carries a word to be driven this cycle |
| rdData | input | 16 | Read word from the array |
| busData | output | 16 | Word driven on the bus, registered |
| busInv | output | 1 | 1 when busData is complemented |
| pgmData | input | 16 | Program word received from the bus |
| pgmInv | input | 1 | 1 when pgmData arrives complemented |
| pgmWord | output | 16 | Restored program word |

## Verification
The words in the table are chosen so that the toggle count lands on 0, 7, 8, 9, 15 and 16. This separates the 8/9 threshold from an off-by-one error. Some steps follow an inverted word, so a reference taken from raw rdData would give a different verdict than one taken from the driven value. Other steps start a burst right after a word far from zero, which exposes a reference that fails to clear. Directed steps cover the idle-cycle hold, the pass-through while the feature is off, stickiness across repeated pulses and bursts, and the loss of the enable at reset.

// File: rtl/bus_inv_pkg.sv
package bus_inv_pkg;
  typedef struct packed {
    logic loadWord;
    logic clearPrev;
    logic invEnable;
  } invStrobe_t;
endpackage

// File: rtl/bus_inv_ctrl.sv
module bus_inv_ctrl
  import bus_inv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enableCmd,
  input  logic       burstStart,
  input  logic       wordValid,
  output invStrobe_t strobes
);
  logic enReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enReg <= 1'b0;
    else if (enableCmd) enReg <= 1'b1;
  end

  always_comb begin
    strobes.loadWord  = wordValid;
    strobes.clearPrev = burstStart;
    strobes.invEnable = enReg;
  end

  // R3: once on, stays on until reset
  a_r3_sticky_enable: assert property (@(posedge clk) disable iff (!rstN)
    enReg |=> enReg);
  // R3: a pulse turns the feature on
  a_r3_pulse_enables: assert property (@(posedge clk) disable iff (!rstN)
    enableCmd |=> strobes.invEnable);
endmodule

// File: rtl/bus_inv_datapath.sv
module bus_inv_datapath
  import bus_inv_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  invStrobe_t        strobes,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] busData,
  output logic              busInv,
  input  logic [DATA_W-1:0] pgmData,
  input  logic              pgmInv,
  output logic [DATA_W-1:0] pgmWord
);
  localparam int HALF_W = DATA_W / 2;
  localparam int THRESH = HALF_W + 1;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] prevWord;
  logic [DATA_W-1:0] baseWord;
  logic [DATA_W-1:0] toggleMask;
  logic [CNT_W-1:0]  toggleCnt;
  logic              doInv;
  logic [DATA_W-1:0] encWord;

  function automatic logic [CNT_W-1:0] popCount(input logic [DATA_W-1:0] v);
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < DATA_W; i++) acc = acc + CNT_W'(v[i]);
    return acc;
  endfunction

  always_comb begin
    baseWord   = strobes.clearPrev ? '0 : prevWord;
    toggleMask = baseWord ^ rdData;
    toggleCnt  = popCount(toggleMask);
    doInv      = strobes.invEnable && (toggleCnt >= CNT_W'(THRESH));
    encWord    = doInv ? ~rdData : rdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWord <= '0;
      busData  <= '0;
      busInv   <= 1'b0;
    end else if (strobes.loadWord) begin
      prevWord <= encWord;
      busData  <= encWord;
      busInv   <= doInv;
    end else if (strobes.clearPrev) begin
      prevWord <= '0;
    end
  end

  genvar b;
  generate
    for (b = 0; b < DATA_W; b++) begin : g_pgmDecode
      assign pgmWord[b] = pgmData[b] ^ pgmInv;
    end
  endgenerate

  // R4/R5/R6: at most HALF_W lines switch against the reference when enabled
  a_r5_bounded_toggles: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadWord && strobes.invEnable) |=>
      ($countones(busData ^ $past(baseWord)) <= HALF_W));
  // R5: the flag and the bus together restore the original word
  a_r5_restorable: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadWord |=> ((busInv ? ~busData : busData) == $past(rdData)));
  // R2: pass-through while disabled
  a_r2_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadWord && !strobes.invEnable) |=> (!busInv && busData == $past(rdData)));
  // R8: outputs hold without a valid word
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadWord |=> ($stable(busData) && $stable(busInv)));
  // R7: a burst start without a word leaves a zero reference
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearPrev && !strobes.loadWord) |=> (prevWord == '0));
endmodule

// File: rtl/bus_inv_codec.sv
module bus_inv_codec
  import bus_inv_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enableCmd,
  input  logic              burstStart,
  input  logic              wordValid,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] busData,
  output logic              busInv,
  input  logic [DATA_W-1:0] pgmData,
  input  logic              pgmInv,
  output logic [DATA_W-1:0] pgmWord
);
  invStrobe_t strobes;

  bus_inv_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .enableCmd(enableCmd),
    .burstStart(burstStart), .wordValid(wordValid), .strobes(strobes)
  );

  bus_inv_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdData(rdData),
    .busData(busData), .busInv(busInv),
    .pgmData(pgmData), .pgmInv(pgmInv), .pgmWord(pgmWord)
  );
endmodule

// File: tb/bus_inv_codec_tb.sv
module bus_inv_codec_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enableCmd = 1'b0;
  logic        burstStart = 1'b0;
  logic        wordValid = 1'b0;
  logic [15:0] rdData = '0;
  logic [15:0] busData;
  logic        busInv;
  logic [15:0] pgmData = '0;
  logic        pgmInv = 1'b0;
  logic [15:0] pgmWord;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  bus_inv_codec dut_i (
    .clk(clk), .rstN(rstN), .enableCmd(enableCmd), .burstStart(burstStart),
    .wordValid(wordValid), .rdData(rdData), .busData(busData), .busInv(busInv),
    .pgmData(pgmData), .pgmInv(pgmInv), .pgmWord(pgmWord)
  );

  // {burstStart, rdData, expected busData, expected busInv}
  localparam logic [33:0] VECS [10] = '{
    {1'b1, 16'h00FF, 16'h00FF, 1'b0},  // R7 R4: 8 toggles vs zero
    {1'b0, 16'hFFFF, 16'hFFFF, 1'b0},  // R4: 8 toggles
    {1'b0, 16'h0000, 16'hFFFF, 1'b1},  // R5: 16 toggles
    {1'b0, 16'h01FF, 16'h01FF, 1'b0},  // R4: 7 toggles
    {1'b0, 16'hFE00, 16'h01FF, 1'b1},  // R5: 16 toggles
    {1'b0, 16'h0000, 16'hFFFF, 1'b1},  // R6 R5: 9 vs driven 01FF, 7 vs raw FE00
    {1'b0, 16'hFF00, 16'hFF00, 1'b0},  // R4: 8 toggles
    {1'b1, 16'h00FF, 16'h00FF, 1'b0},  // R7: vs zero, not vs FF00
    {1'b0, 16'hFF01, 16'h00FE, 1'b1},  // R5: 15 toggles
    {1'b0, 16'h00FE, 16'h00FE, 1'b0}   // R4: 0 toggles
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic start, input logic [15:0] d);
    @(negedge clk);
    burstStart = start; wordValid = 1'b1; rdData = d;
    @(negedge clk);
    burstStart = 1'b0; wordValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset busData", 32'(busData), 32'h0);
    check("R1 reset busInv", 32'(busInv), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release busData", 32'(busData), 32'h0);
    check("R1 after release busInv", 32'(busInv), 32'h0);

    // R2 disabled pass-through
    sendWord(1'b1, 16'h0000);
    sendWord(1'b0, 16'hFFFF);
    check("R2 pass busData", 32'(busData), 32'hFFFF);
    check("R2 pass busInv", 32'(busInv), 32'h0);

    // R9 inbound decode while disabled
    pgmData = 16'h1234; pgmInv = 1'b1; #1;
    check("R9 inverted restore off", 32'(pgmWord), 32'hEDCB);
    pgmInv = 1'b0; #1;
    check("R9 as-is off", 32'(pgmWord), 32'h1234);

    // R3 enable pulse
    @(negedge clk); enableCmd = 1'b1;
    @(negedge clk); enableCmd = 1'b0;

    for (int i = 0; i < 10; i++) begin
      sendWord(VECS[i][33], VECS[i][32:17]);
      check($sformatf("R4/R5 vec%0d busData", i), 32'(busData), 32'(VECS[i][16:1]));
      check($sformatf("R4/R5 vec%0d busInv", i), 32'(busInv), 32'(VECS[i][0]));
    end

    // R8 hold without wordValid; reference stays 00FE
    @(negedge clk); rdData = 16'hAAAA;
    repeat (3) @(negedge clk);
    check("R8 hold busData", 32'(busData), 32'h00FE);
    check("R8 hold busInv", 32'(busInv), 32'h0);
    sendWord(1'b0, 16'h01FF);  // 2 toggles vs 00FE
    check("R8 reference kept", 32'(busData), 32'h01FF);

    // R7 burstStart alone clears reference; 01FF vs zero = 9
    @(negedge clk); burstStart = 1'b1;
    @(negedge clk); burstStart = 1'b0;
    sendWord(1'b0, 16'h01FF);
    check("R7 cleared busData", 32'(busData), 32'hFE00);
    check("R7 cleared busInv", 32'(busInv), 32'h1);

    // R3 sticky: another pulse, idle cycles, a new burst
    @(negedge clk); enableCmd = 1'b1;
    @(negedge clk); enableCmd = 1'b0;
    repeat (20) @(negedge clk);
    sendWord(1'b1, 16'hFFFF);
    check("R3 sticky busData", 32'(busData), 32'h0000);
    check("R3 sticky busInv", 32'(busInv), 32'h1);

    // R9 inbound decode while enabled
    pgmData = 16'h0F0F; pgmInv = 1'b1; #1;
    check("R9 inverted restore on", 32'(pgmWord), 32'hF0F0);
    pgmInv = 1'b0; #1;
    check("R9 as-is on", 32'(pgmWord), 32'h0F0F);

    // R10 reset disables
    doReset();
    check("R1 reset again busData", 32'(busData), 32'h0);
    sendWord(1'b1, 16'hFFFF);
    check("R10 disabled busData", 32'(busData), 32'hFFFF);
    check("R10 disabled busInv", 32'(busInv), 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule